// File: doc/BRIEF.md
# Registered 4-bit ALU Datapath

This block is a small synchronous datapath around a 4-bit combinational arithmetic unit. Two operand registers, each with its own load and clear controls, hold the values that feed the arithmetic unit. A 2-bit operation select chooses one of four fixed functions. A result register with no enable captures the unit's output on every rising clock edge.

A combinational 4-to-1 view multiplexer drives the single data output. It shows the first operand register, the second operand register, the result register, or a constant zero. A typical use is to load both operands, wait one clock for the result register to pick up the computed value, and then select the result on the view multiplexer. A synchronous active-high reset brings every register to zero.

Top module: `alu4_datapath`

## Requirements
- R1: With `op_sel` = 2'b00 the unit adds the two operand registers, keeps only the low 4 bits and gives no carry.
- R2: With `op_sel` = 2'b01 the unit subtracts operand B from operand A modulo 16 and gives no borrow.
- R3: With `op_sel` = 2'b10 the unit gives 4'b0001 when operand A is less than operand B, comparing them as unsigned numbers, and 4'b0000 otherwise.
- R4: With `op_sel` = 2'b11 the unit gives the bitwise AND of the two operand registers.
- R5: An operand register whose load is 1 and whose clear is 0 takes its data input at the next rising edge.
- R6: An operand register whose load and clear are both 0 keeps its value across the edge.
- R7: An operand register whose clear is 1 becomes zero at the next rising edge, whatever its load input is.
- R8: The result register captures the unit's output, computed from the operand register values present before the edge, on every rising edge with no enable.
- R9: `view_sel` maps 2'b00 to operand A, 2'b01 to operand B, 2'b10 to the result register and 2'b11 to constant zero.
- R10: While `rst` is 1 at a rising edge, all three registers become zero, and they read zero right after reset is released.
- R11: `view_out` follows a change of `view_sel` within the same clock cycle, with no edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 4 | Data input for operand register A |
| b_in | input | 4 | Data input for operand register B |
| a_load | input | 1 | Load enable of operand register A |
| a_clear | input | 1 | Clear of operand register A, overrides load |
| b_load | input | 1 | Load enable of operand register B |
| b_clear | input | 1 | Clear of operand register B, overrides load |
| op_sel | input | 2 | Operation select: add, subtract, set-less-than, AND |
| view_sel | input | 2 | Selects which value drives view_out |
| view_out | output | 4 | Selected register value or zero |

## Verification
An operand change is visible on the view output one edge after its load or clear. A result that depends on newly loaded operands becomes visible one edge after that, because the result register samples the operands as they were before the loading edge. The view multiplexer adds no delay. The bench drives inputs on the falling edge and keeps a cycle-accurate model that updates at each rising edge from the pre-edge values. After each edge it steps `view_sel` through all four codes within the same high phase and compares each code's output against the model before the next edge. Random cycles are mixed with directed cases for clear-over-load, hold, wraparound, and equal and unequal compare operands.

// File: rtl/alu4_pkg.sv
`timescale 1ns/1ps
package alu4_pkg;

    localparam int DATA_W = 4;
    localparam int OP_W   = 2;
    localparam int VIEW_W = 2;
    localparam int N_OPND = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_SLT = 2'b10,
        OP_AND = 2'b11
    } alu_op_e;

    typedef enum logic [VIEW_W-1:0] {
        VIEW_A    = 2'b00,
        VIEW_B    = 2'b01,
        VIEW_Y    = 2'b10,
        VIEW_ZERO = 2'b11
    } view_e;

    typedef struct packed {
        logic load;
        logic clear;
    } opnd_ctl_t;

    // Unsigned compare yields 1 in the LSB only.
    function automatic word_t slt_u(input word_t a, input word_t b);
        word_t r;
        r = '0;
        r[0] = (a < b);
        return r;
    endfunction

    function automatic word_t alu_eval(input alu_op_e op, input word_t a, input word_t b);
        word_t r;
        unique case (op)
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_SLT:  r = slt_u(a, b);
            default: r = a & b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu4_opnd_reg.sv
`timescale 1ns/1ps
module alu4_opnd_reg
    import alu4_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  opnd_ctl_t ctl,
    input  word_t     d,
    output word_t     q
);

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            q <= '0;
        end else if (ctl.load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/alu4_core.sv
`timescale 1ns/1ps
module alu4_core
    import alu4_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);

    always_comb begin
        y = alu_eval(op, a, b);
    end

endmodule

// File: rtl/alu4_view_mux.sv
`timescale 1ns/1ps
module alu4_view_mux
    import alu4_pkg::*;
(
    input  view_e sel,
    input  word_t opnd_a,
    input  word_t opnd_b,
    input  word_t result,
    output word_t dout
);

    always_comb begin
        unique case (sel)
            VIEW_A:  dout = opnd_a;
            VIEW_B:  dout = opnd_b;
            VIEW_Y:  dout = result;
            default: dout = '0;
        endcase
    end

endmodule

// File: rtl/alu4_datapath.sv
`timescale 1ns/1ps
module alu4_datapath
    import alu4_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              a_load,
    input  logic              a_clear,
    input  logic              b_load,
    input  logic              b_clear,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [VIEW_W-1:0] view_sel,
    output logic [DATA_W-1:0] view_out
);

    word_t     opnd_d [N_OPND];
    word_t     opnd_q [N_OPND];
    opnd_ctl_t opnd_c [N_OPND];

    word_t a_q;
    word_t b_q;
    word_t alu_y;
    word_t y_q;

    assign opnd_d[0] = a_in;
    assign opnd_d[1] = b_in;
    assign opnd_c[0] = '{load: a_load, clear: a_clear};
    assign opnd_c[1] = '{load: b_load, clear: b_clear};

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        alu4_opnd_reg u_reg (
            .clk (clk),
            .rst (rst),
            .ctl (opnd_c[i]),
            .d   (opnd_d[i]),
            .q   (opnd_q[i])
        );
    end

    assign a_q = opnd_q[0];
    assign b_q = opnd_q[1];

    alu4_core u_core (
        .op (alu_op_e'(op_sel)),
        .a  (a_q),
        .b  (b_q),
        .y  (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
        end else begin
            y_q <= alu_y;
        end
    end

    alu4_view_mux u_view (
        .sel    (view_e'(view_sel)),
        .opnd_a (a_q),
        .opnd_b (b_q),
        .result (y_q),
        .dout   (view_out)
    );

endmodule

// File: rtl/alu4_datapath_chk.sv
`timescale 1ns/1ps
module alu4_datapath_chk
    import alu4_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] b_in,
    input logic              a_load,
    input logic              a_clear,
    input logic              b_load,
    input logic              b_clear,
    input logic [OP_W-1:0]   op_sel,
    input logic [VIEW_W-1:0] view_sel,
    input logic [DATA_W-1:0] view_out,
    input logic [DATA_W-1:0] a_q,
    input logic [DATA_W-1:0] b_q,
    input logic [DATA_W-1:0] y_q
);

    a_r7_clear_a: assert property (@(posedge clk) disable iff (rst)
        a_clear |=> (a_q == '0));
    a_r7_clear_b: assert property (@(posedge clk) disable iff (rst)
        b_clear |=> (b_q == '0));

    a_r5_load_a: assert property (@(posedge clk) disable iff (rst)
        (a_load && !a_clear) |=> (a_q == $past(a_in)));
    a_r5_load_b: assert property (@(posedge clk) disable iff (rst)
        (b_load && !b_clear) |=> (b_q == $past(b_in)));

    a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
        (!a_load && !a_clear) |=> $stable(a_q));
    a_r6_hold_b: assert property (@(posedge clk) disable iff (rst)
        (!b_load && !b_clear) |=> $stable(b_q));

    // R3: compare result never sets bits above the LSB
    a_r3_slt_lsb_only: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b10) |=> (y_q[DATA_W-1:1] == '0));

    // R4: AND result is a bit subset of both operands
    a_r4_and_subset: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b11) |=> ((y_q & ~($past(a_q) & $past(b_q))) == '0));

    a_r9_zero_view: assert property (@(posedge clk) disable iff (rst)
        (view_sel == 2'b11) |-> (view_out == '0));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> ((a_q == '0) && (b_q == '0) && (y_q == '0)));

endmodule

bind alu4_datapath alu4_datapath_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_load   (a_load),
    .a_clear  (a_clear),
    .b_load   (b_load),
    .b_clear  (b_clear),
    .op_sel   (op_sel),
    .view_sel (view_sel),
    .view_out (view_out),
    .a_q      (a_q),
    .b_q      (b_q),
    .y_q      (y_q)
);

// File: tb/alu4_datapath_tb.sv
`timescale 1ns/1ps
module alu4_datapath_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic       a_load = 1'b0;
    logic       a_clear = 1'b0;
    logic       b_load = 1'b0;
    logic       b_clear = 1'b0;
    logic [1:0] op_sel = '0;
    logic [1:0] view_sel = '0;
    logic [3:0] view_out;

    int checks = 0;
    int errors = 0;

    logic [3:0] m_a = '0;
    logic [3:0] m_b = '0;
    logic [3:0] m_y = '0;

    always #2.5 clk = ~clk;

    alu4_datapath u_dut (
        .clk      (clk),
        .rst      (rst),
        .a_in     (a_in),
        .b_in     (b_in),
        .a_load   (a_load),
        .a_clear  (a_clear),
        .b_load   (b_load),
        .b_clear  (b_clear),
        .op_sel   (op_sel),
        .view_sel (view_sel),
        .view_out (view_out)
    );

    function automatic logic [3:0] exp_alu(input logic [1:0] op, input logic [3:0] a, input logic [3:0] b);
        int s;
        case (op)
            2'b00:   s = (int'(a) + int'(b)) % 16;
            2'b01:   s = (int'(a) - int'(b) + 16) % 16;
            2'b10:   s = (int'(a) < int'(b)) ? 1 : 0;
            default: s = int'(a & b);
        endcase
        return s[3:0];
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic string reg_tag(input logic ld, input logic cl);
        if (cl) return "R7";
        if (ld) return "R5";
        return "R6";
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // View all four codes within the high phase after an edge.
    task automatic check_views(input string ta, input string tb, input string ty);
        view_sel = 2'b00; #0.4; check(ta, view_out, m_a);
        view_sel = 2'b01; #0.4; check(tb, view_out, m_b);
        view_sel = 2'b10; #0.4; check(ty, view_out, m_y);
        view_sel = 2'b11; #0.4; check("R9", view_out, 4'h0);
    endtask

    task automatic step(input logic la, input logic ca, input logic [3:0] da,
                        input logic lb, input logic cb, input logic [3:0] db,
                        input logic [1:0] op, input string ty_override);
        logic [3:0] ny;
        string ty;
        @(negedge clk);
        a_load = la; a_clear = ca; a_in = da;
        b_load = lb; b_clear = cb; b_in = db;
        op_sel = op;
        @(posedge clk);
        ny = exp_alu(op, m_a, m_b);
        if (ca) m_a = 4'h0; else if (la) m_a = da;
        if (cb) m_b = 4'h0; else if (lb) m_b = db;
        m_y = ny;
        ty = (ty_override.len() != 0) ? ty_override : op_tag(op);
        #0.3;
        check_views(reg_tag(la, ca), reg_tag(lb, cb), ty);
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // Reset with loads active: registers must still be zero (R10)
        a_load = 1'b1; b_load = 1'b1; a_in = 4'hF; b_in = 4'hA;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; a_load = 1'b0; b_load = 1'b0;
        #0.3;
        check_views("R10", "R10", "R10");

        // Wraparound add: 9+9 = 2 (R1)
        step(1, 0, 4'h9, 1, 0, 4'h9, 2'b00, "");
        step(0, 0, 4'h0, 0, 0, 4'h0, 2'b00, "R1");
        // Sub wrap: 3-5 = E (R2)
        step(1, 0, 4'h3, 1, 0, 4'h5, 2'b01, "");
        step(0, 0, 4'h0, 0, 0, 4'h0, 2'b01, "R2");
        // Compare: 3<5 -> 1; equal -> 0; F vs 1 -> 0 (unsigned) (R3)
        step(0, 0, 4'h0, 0, 0, 4'h0, 2'b10, "R3");
        step(1, 0, 4'h5, 0, 0, 4'h0, 2'b10, "");
        step(0, 0, 4'h0, 0, 0, 4'h0, 2'b10, "R3");
        step(1, 0, 4'hF, 1, 0, 4'h1, 2'b10, "");
        step(0, 0, 4'h0, 0, 0, 4'h0, 2'b10, "R3");
        // AND (R4)
        step(0, 0, 4'h0, 0, 0, 4'h0, 2'b11, "R4");
        // Result follows op on every edge with operands held (R8)
        for (int k = 0; k < 4; k++) begin
            step(0, 0, 4'h0, 0, 0, 4'h0, 2'(k), "R8");
        end
        // Clear beats load on both registers (R7)
        step(1, 1, 4'h7, 1, 1, 4'h6, 2'b00, "");
        step(0, 0, 4'h0, 0, 0, 4'h0, 2'b00, "R8");
        // Hold with changing data inputs (R6)
        step(1, 0, 4'hC, 0, 0, 4'h3, 2'b00, "");
        step(0, 0, 4'h1, 0, 0, 4'h2, 2'b00, "");

        // View follows select without an edge (R11)
        @(negedge clk);
        view_sel = 2'b00; #0.3; check("R11", view_out, m_a);
        view_sel = 2'b10; #0.3; check("R11", view_out, m_y);
        view_sel = 2'b11; #0.3; check("R11", view_out, 4'h0);

        // Random cycles
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], (r[3:1] == 3'b000), r[7:4],
                 r[8], (r[11:9] == 3'b000), r[15:12],
                 r[17:16], "");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule